// File: doc/BRIEF.md
# Synchronous Burst SRAM Front-End

This block is a cycle-accurate, synthesizable model of a single-ported synchronous burst SRAM. Every control input is sampled on the rising clock edge. Three chip selects, two address strobes and a step input are decoded into five cycle kinds: idle, deselect, begin-burst, continue-burst and suspend-burst. A 2-bit burst counter produces the low two address bits of each beat, in either linear or interleaved order. Writes go to all byte lanes at once or to selected lanes only.

The read path has two modes, chosen by a static pin. In flow-through mode, read data leaves right after the capture edge. In pipelined mode it passes through one more output register. The output enable acts without the clock. Bus ownership follows a single-cycle-deselect rule: a captured deselect removes the drivers after its own edge, in both modes.

The shared data bus is modelled as a separate write-data input, a read-data output and one driver-enable output that covers all lanes. A surrounding pad ring or bus model turns these into a bidirectional bus. Write data is sampled on the same edge as its write command.

Top module: `sync_burst_sram`

## Requirements
- R1: The device is enabled only when sel1_i=1, sel0_ni=0 and sel2_ni=0. A strobe cycle with any other combination of these three is a deselect, and it closes the open burst.
- R2: sel0_ni=1 masks strb_a_ni. A cycle with strb_b_ni=1 and strb_a_ni low, or masked, continues or suspends the open burst. sel1_i and sel2_ni are ignored in that cycle.
- R3: An enabled strb_a_ni cycle always begins a read at addr_i, whatever the write controls and strb_b_ni are. A write burst begins only through strb_b_ni=0 when strb_a_ni is high or masked.
- R4: With both strobes high and a burst open, step_ni=0 moves to the next beat address and step_ni=1 repeats the current one. Both reads and writes are allowed in these cycles.
- R5: Only addr bits 1:0 change during a burst. With ilv_i=1, beat n uses start XOR n. With ilv_i=0, it uses (start + n) mod 4. The sequence wraps after four beats.
- R6: wr_all_ni=0 writes all lanes. Otherwise wr_byte_ni=0 writes each lane i (data bits 8i+7:8i) whose lane_ni[i]=0. wr_byte_ni=0 with lane_ni all ones is a write cycle that changes no lane.
- R7: drive_o is 0 during any write cycle, whatever the lane selects are. When a read drives, one enable covers all lanes.
- R8: With pipe_i=0, a read captured at edge k drives its data after edge k. With pipe_i=1, it drives after edge k+1.
- R9: A deselect captured at edge k sets drive_o to 0 right after edge k, in both modes. In pipelined mode this also cuts off a read captured at edge k-1.
- R10: oe_ni=1 forces drive_o to 0 without waiting for a clock edge. A read performed with oe_ni=1 still advances the burst.
- R11: Continue and suspend cycles with no open burst (after reset or a deselect) neither write nor drive.
- R12: While rst_ni is low, drive_o is 0 and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Word address, loaded on begin-burst cycles |
| wdata_i | input | 8*NB | Write data, sampled with the write command |
| sel0_ni | input | 1 | Chip select, active low; also masks strb_a_ni |
| sel1_i | input | 1 | Chip select, active high |
| sel2_ni | input | 1 | Chip select, active low |
| strb_a_ni | input | 1 | Priority address strobe, read-only start |
| strb_b_ni | input | 1 | Secondary address strobe, read or write start |
| step_ni | input | 1 | Burst advance when low, hold when high |
| wr_all_ni | input | 1 | Write all lanes, active low |
| wr_byte_ni | input | 1 | Lane-selective write, active low |
| lane_ni | input | NB | Per-lane write selects, active low |
| oe_ni | input | 1 | Output enable, active low, unclocked |
| pipe_i | input | 1 | 1 selects pipelined reads, 0 flow-through |
| ilv_i | input | 1 | 1 selects interleaved order, 0 linear |
| rdata_o | output | 8*NB | Read data, valid while drive_o is 1 |
| drive_o | output | 1 | Bus driver enable for all lanes |

## Verification
A wrong burst count or base address appears as wrong rdata_o on the next driven beat. That is one edge after the read in flow-through mode and two edges after it in pipelined mode. A wrong written lane stays hidden until that word is read back. A stale open-burst flag shows as drive_o rising, or a write taking effect, in cycles that should be idle after a deselect. A wrong deselect or write qualifier shows at once as drive_o high in a cycle where the bus belongs to the host.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_DESEL,
    CYC_BEGIN,
    CYC_CONT,
    CYC_SUSP
  } cyc_e;

  typedef struct packed {
    cyc_e kind;
    logic wr;
  } cmd_t;

  // low address bits of beat n from start s
  function automatic logic [1:0] burst_lo(input logic [1:0] s, input logic [1:0] n,
                                          input logic ilv);
    return ilv ? (s ^ n) : (s + n);
  endfunction
endpackage

// File: rtl/sbs_decode.sv
module sbs_decode
  import sbs_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel0_ni,
  input  logic          sel1_i,
  input  logic          sel2_ni,
  input  logic          strb_a_ni,
  input  logic          strb_b_ni,
  input  logic          step_ni,
  input  logic          wr_all_ni,
  input  logic          wr_byte_ni,
  input  logic [NB-1:0] lane_ni,
  input  logic          open_i,
  output cmd_t          cmd_o,
  output logic [NB-1:0] lane_we_o
);
  logic enabled, take_a, take_b, wr_req;

  assign enabled = sel1_i & ~sel0_ni & ~sel2_ni;
  assign take_a  = ~strb_a_ni & ~sel0_ni;
  assign take_b  = ~strb_b_ni & ~take_a;
  assign wr_req  = ~wr_all_ni | ~wr_byte_ni;

  always_comb begin
    cmd_o = '{kind: CYC_IDLE, wr: 1'b0};
    if (take_a) begin
      cmd_o.kind = enabled ? CYC_BEGIN : CYC_DESEL;
    end else if (take_b) begin
      cmd_o.kind = enabled ? CYC_BEGIN : CYC_DESEL;
      cmd_o.wr   = enabled & wr_req;
    end else if (open_i) begin
      cmd_o.kind = step_ni ? CYC_SUSP : CYC_CONT;
      cmd_o.wr   = wr_req;
    end
  end

  always_comb begin
    lane_we_o = '0;
    if (cmd_o.wr) lane_we_o = ~wr_all_ni ? '1 : ~lane_ni;
  end

  AST_A_READS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strb_a_ni && enabled) |-> (cmd_o.kind == CYC_BEGIN && !cmd_o.wr)); // R3
  AST_A_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel0_ni && strb_b_ni && open_i) |-> (cmd_o.kind inside {CYC_CONT, CYC_SUSP})); // R2
  AST_NO_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_all_ni && !wr_byte_ni && (&lane_ni)) |-> (lane_we_o == '0)); // R6
  AST_DESEL_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strb_b_ni && !enabled) |-> (cmd_o.kind == CYC_DESEL)); // R1
endmodule

// File: rtl/sbs_burst.sv
module sbs_burst
  import sbs_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cyc_e          kind_i,
  input  logic [AW-1:0] addr_i,
  input  logic          ilv_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q, cnt_nxt;

  assign cnt_nxt = cnt_q + 2'd1;

  always_comb begin
    unique case (kind_i)
      CYC_BEGIN: addr_o = addr_i;
      CYC_CONT:  addr_o = {base_q[AW-1:2], burst_lo(base_q[1:0], cnt_nxt, ilv_i)};
      default:   addr_o = {base_q[AW-1:2], burst_lo(base_q[1:0], cnt_q, ilv_i)};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (kind_i == CYC_BEGIN) begin
      base_q <= addr_i;
      cnt_q  <= '0;
    end else if (kind_i == CYC_CONT) begin
      cnt_q  <= cnt_nxt;
    end
  end

  AST_BEGIN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == CYC_BEGIN) |=> (cnt_q == 2'd0 && base_q == $past(addr_i))); // R5
  AST_CONT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == CYC_CONT) |=> (cnt_q == $past(cnt_q) + 2'd1)); // R4
  AST_SUSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == CYC_SUSP) |=> ($stable(cnt_q) && $stable(base_q))); // R4
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int AW = 6,
  parameter int NB = 4,
  localparam int DW = 8 * NB,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic [AW-1:0] addr_i,
  input  logic [NB-1:0] lane_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] bit_we;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign bit_we[8*i +: 8] = {8{lane_we_i[i]}};
  end

  always_ff @(posedge clk_i) begin
    mem[addr_i] <= (mem[addr_i] & ~bit_we) | (wdata_i & bit_we);
    if (rd_en_i) rdata_o <= mem[addr_i];
  end
endmodule

// File: rtl/sbs_outpath.sv
module sbs_outpath #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pipe_i,
  input  logic          rd_cap_i,
  input  logic          desel_i,
  input  logic          wr_now_i,
  input  logic          oe_ni,
  input  logic [DW-1:0] flow_data_i,
  output logic [DW-1:0] rdata_o,
  output logic          drive_o
);
  logic          rd_q, pv_q, desel_q;
  logic [DW-1:0] pipe_q;
  logic          own;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= 1'b0;
      pv_q    <= 1'b0;
      desel_q <= 1'b0;
    end else begin
      rd_q    <= rd_cap_i;
      pv_q    <= rd_q;
      desel_q <= desel_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rd_q) pipe_q <= flow_data_i;
  end

  // a captured deselect cuts the output register's beat one stage early
  assign own     = pipe_i ? (pv_q & ~desel_q) : rd_q;
  assign drive_o = own & ~oe_ni & ~wr_now_i;
  assign rdata_o = pipe_i ? pipe_q : flow_data_i;

  AST_DESEL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desel_i |=> !drive_o); // R9
  AST_OE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !drive_o); // R10
  AST_WR_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_now_i |-> !drive_o); // R7
  AST_PIPE_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_i && !rd_cap_i) |=> ##1 (!pipe_i || !drive_o)); // R8
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 4,
  localparam int DW = 8 * NB
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          sel0_ni,
  input  logic          sel1_i,
  input  logic          sel2_ni,
  input  logic          strb_a_ni,
  input  logic          strb_b_ni,
  input  logic          step_ni,
  input  logic          wr_all_ni,
  input  logic          wr_byte_ni,
  input  logic [NB-1:0] lane_ni,
  input  logic          oe_ni,
  input  logic          pipe_i,
  input  logic          ilv_i,
  output logic [DW-1:0] rdata_o,
  output logic          drive_o
);
  cmd_t          cmd;
  logic [NB-1:0] lane_we;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] arr_data;
  logic          open_q, active, rd_cap;

  assign active = cmd.kind inside {CYC_BEGIN, CYC_CONT, CYC_SUSP};
  assign rd_cap = active & ~cmd.wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    open_q <= 1'b0;
    else if (cmd.kind == CYC_BEGIN) open_q <= 1'b1;
    else if (cmd.kind == CYC_DESEL) open_q <= 1'b0;
  end

  sbs_decode #(.NB(NB)) u_decode (
    .clk_i, .rst_ni, .sel0_ni, .sel1_i, .sel2_ni, .strb_a_ni, .strb_b_ni,
    .step_ni, .wr_all_ni, .wr_byte_ni, .lane_ni,
    .open_i(open_q), .cmd_o(cmd), .lane_we_o(lane_we)
  );

  sbs_burst #(.AW(AW)) u_burst (
    .clk_i, .rst_ni, .kind_i(cmd.kind), .addr_i, .ilv_i, .addr_o(cur_addr)
  );

  sbs_array #(.AW(AW), .NB(NB)) u_array (
    .clk_i, .addr_i(cur_addr), .lane_we_i(lane_we), .wdata_i,
    .rd_en_i(rd_cap), .rdata_o(arr_data)
  );

  sbs_outpath #(.DW(DW)) u_out (
    .clk_i, .rst_ni, .pipe_i, .rd_cap_i(rd_cap), .desel_i(cmd.kind == CYC_DESEL),
    .wr_now_i(cmd.wr), .oe_ni, .flow_data_i(arr_data), .rdata_o, .drive_o
  );

  AST_IDLE_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd.kind == CYC_DESEL) |=> !open_q); // R11
  AST_IDLE_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_q && strb_a_ni && strb_b_ni) |-> (lane_we == '0 && !rd_cap)); // R11
endmodule

// File: tb/sim_sync_burst_sram.sv
module sim_sync_burst_sram;
  localparam int CLK_P = 10;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int DW = 8 * NB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr;
  logic [DW-1:0] wd, rdata;
  logic s0, s1, s2, sa, sb, stp, wall, wbyte, oe, pipe, ilv, drive;
  logic [NB-1:0] lane;

  int checks = 0, fails = 0, seq = 0;

  typedef struct {
    bit rd;
    logic [DW-1:0] d;
    bit ds;
  } ent_t;

  ent_t          hist[$];
  logic [DW-1:0] m_mem [64];
  bit            m_open;
  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;

  always #(CLK_P/2) clk = ~clk;

  sync_burst_sram #(.AW(AW), .NB(NB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wd),
    .sel0_ni(s0), .sel1_i(s1), .sel2_ni(s2), .strb_a_ni(sa), .strb_b_ni(sb),
    .step_ni(stp), .wr_all_ni(wall), .wr_byte_ni(wbyte), .lane_ni(lane),
    .oe_ni(oe), .pipe_i(pipe), .ilv_i(ilv), .rdata_o(rdata), .drive_o(drive)
  );

  // kind: 0 idle, 1 deselect, 2 begin, 3 continue, 4 suspend
  function automatic void classify(output int kind, output bit wr);
    bit en, ta, tb;
    en = s1 && !s0 && !s2;
    ta = !sa && !s0;
    tb = !sb && !ta;
    wr = 0;
    if (ta) kind = en ? 2 : 1;
    else if (tb) begin
      kind = en ? 2 : 1;
      wr = en && (!wall || !wbyte);
    end else if (!m_open) kind = 0;
    else begin
      kind = stp ? 4 : 3;
      wr = !wall || !wbyte;
    end
  endfunction

  function automatic logic [1:0] lo(input logic [1:0] s, input logic [1:0] n);
    return ilv ? (s ^ n) : 2'((int'(s) + int'(n)) % 4);
  endfunction

  task automatic model_reset();
    hist.delete();
    hist.push_back('{rd: 0, d: 'x, ds: 0});
    hist.push_back('{rd: 0, d: 'x, ds: 0});
    m_open = 0;
    m_base = '0;
    m_cnt  = '0;
  endtask

  task automatic model_edge();
    int k;
    bit w;
    logic [AW-1:0] a;
    ent_t e;
    classify(k, w);
    a = addr;
    if (k == 3) a = {m_base[AW-1:2], lo(m_base[1:0], m_cnt + 2'd1)};
    else if (k == 4) a = {m_base[AW-1:2], lo(m_base[1:0], m_cnt)};
    if (w) begin
      for (int i = 0; i < NB; i++)
        if (!wall || (!wbyte && !lane[i])) m_mem[a][8*i +: 8] = wd[8*i +: 8];
    end
    e.rd = (k >= 2) && !w;
    e.d  = e.rd ? m_mem[a] : hist[$].d;
    e.ds = (k == 1);
    hist.push_back(e);
    if (hist.size() > 2) void'(hist.pop_front());
    if (k == 2) begin
      m_open = 1;
      m_base = addr;
      m_cnt  = 0;
    end else if (k == 3) m_cnt = m_cnt + 2'd1;
    else if (k == 1) m_open = 0;
  endtask

  task automatic compare(input string tag);
    int k;
    bit w, exp_drv;
    logic [DW-1:0] exp_d;
    classify(k, w);
    if (!rst_n) exp_drv = 0;
    else if (pipe) exp_drv = !oe && !w && hist[0].rd && !hist[1].ds;
    else exp_drv = !oe && !w && hist[1].rd;
    exp_d = pipe ? hist[0].d : hist[1].d;
    checks++;
    if (drive !== exp_drv) begin
      fails++;
      $display("FAIL %s: drive=%0b expected %0b (pipe=%0b ilv=%0b t=%0t)",
               tag, drive, exp_drv, pipe, ilv, $time);
    end
    if (exp_drv && !$isunknown(exp_d)) begin
      checks++;
      if (rdata !== exp_d) begin
        fails++;
        $display("FAIL %s: rdata=%h expected %h (pipe=%0b ilv=%0b t=%0t)",
                 tag, rdata, exp_d, pipe, ilv, $time);
      end
    end
  endtask

  task automatic set_def();
    s0 = 0; s1 = 1; s2 = 0; sa = 1; sb = 1; stp = 1;
    wall = 1; wbyte = 1; lane = '1; oe = 0; addr = '0;
    seq++;
    wd = 32'(seq) * 32'h9E37_79B1;
  endtask

  task automatic tick(input string tag);
    #1;
    compare(tag);
    @(posedge clk);
    if (!rst_n) model_reset();
    else model_edge();
    @(negedge clk);
  endtask

  task automatic run_pass(input bit p, input bit il);
    pipe = p;
    ilv  = il;
    set_def();
    rst_n = 0;
    @(negedge clk);
    model_reset();
    tick("R12");
    tick("R12");
    rst_n = 1;
    set_def(); tick("R12");
    // fill words 0..15 with full-width write bursts
    for (int g = 0; g < 4; g++) begin
      set_def(); sb = 0; wall = 0; addr = AW'(g * 4 + g); tick("R4");
      for (int b = 0; b < 3; b++) begin
        set_def(); stp = 0; wall = 0; tick("R5");
      end
    end
    set_def(); sb = 0; s1 = 0; tick("R1");
    set_def(); stp = 0; wall = 0; tick("R11");
    // priority strobe read burst with write controls asserted
    set_def(); sa = 0; wall = 0; addr = 6'd6; tick("R3");
    for (int b = 0; b < 4; b++) begin
      set_def(); stp = 0; tick("R5");
    end
    set_def(); tick("R4");
    set_def(); s0 = 1; sa = 0; stp = 0; tick("R2");
    set_def(); s1 = 0; s2 = 1; stp = 0; tick("R2");
    // dummy reads with output disabled
    set_def(); oe = 1; stp = 0; tick("R10");
    set_def(); oe = 1; tick("R10");
    // lane-selective write burst started by the secondary strobe
    set_def(); sb = 0; addr = 6'd9; wbyte = 0; lane = 4'b1010; oe = 1; tick("R6");
    set_def(); stp = 0; wbyte = 0; lane = 4'b1111; tick("R6");
    set_def(); stp = 0; wbyte = 0; lane = 4'b0110; tick("R7");
    set_def(); wall = 0; tick("R7");
    set_def(); sb = 0; s2 = 1; tick("R9");
    set_def(); stp = 0; wall = 0; tick("R11");
    set_def(); stp = 0; tick("R11");
    // read back the written words
    set_def(); sb = 0; addr = 6'd8; tick("R8");
    for (int b = 0; b < 3; b++) begin
      set_def(); stp = 0; tick("R8");
    end
    set_def(); oe = 1; tick("R10");
    set_def(); tick("R8");
    // both strobes low: priority strobe wins, read
    set_def(); sa = 0; sb = 0; wall = 0; addr = 6'd1; tick("R3");
    set_def(); stp = 0; tick("R5");
    set_def(); sa = 0; s1 = 0; tick("R9");
    set_def(); tick("R9");
    set_def(); tick("R9");
    // read immediately followed by deselect
    set_def(); sb = 0; addr = 6'd13; tick("R8");
    set_def(); sb = 0; s0 = 1; tick("R9");
    set_def(); tick("R9");
    set_def(); tick("R11");
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    set_def();
    pipe = 0;
    ilv = 0;
    @(negedge clk);
    run_pass(1'b0, 1'b0);
    run_pass(1'b0, 1'b1);
    run_pass(1'b1, 1'b0);
    run_pass(1'b1, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule